// File: doc/BRIEF.md
# Floating-Point Compare-Condition Unit

This unit compares two IEEE-754 operands and reduces the comparison to one boolean under a 4-bit condition mask. The operands can be in single or double precision. The boolean is latched into one bit of a small condition-code vector. A decoder drives the unit with a one-cycle strobe and supplies the following:

- both operands
- a format select
- an absolute-value flag
- the condition mask
- the index of the condition-code bit to update

The unit classifies each operand. It then derives three mutually exclusive relations: less, equal and unordered. The result is the OR of these relations after each one is gated by its mask bit. An invalid-operation pulse is raised for the control-register logic when the compare is unordered and either mask bit 3 asks for signalling or an operand is a signaling NaN.

All outputs are registered and appear one clock after the strobe. The condition-code vector keeps its contents except for the single bit that a strobe writes.

Top module: `fpcmp_cond_unit`

## Requirements
- R1: With `dbl_i`=0, the operands are the low 32 bits of each input, read as single precision (1 sign, 8 exponent, 23 fraction bits). The upper 32 bits have no effect.
- R2: With `dbl_i`=1, each operand is the full 64 bits, read as double precision (1 sign, 11 exponent, 52 fraction bits).
- R3: An operand whose exponent is all ones and whose fraction is nonzero is a NaN. If either operand is a NaN, less and equal are both 0 and unordered is 1, whatever the sign and abs settings are.
- R4: `invalid_o` pulses high for one cycle after a strobe only when the compare was unordered and either `cond_i[3]`=1 or either operand is a signaling NaN. A NaN is signaling when its fraction MSB is 0.
- R5: When `abs_i`=1, both operands are compared with their sign bits cleared.
- R6: Less is 1 only when operand A is numerically below operand B and the two are not equal. +0 and -0 compare equal, subnormals order by magnitude, and infinities lie beyond every finite value.
- R7: The result is `(cond_i[2] & less) | (cond_i[1] & equal) | (cond_i[0] & unordered)`.
- R8: One cycle after a strobe, `cc_o[cc_sel_i]` and `result_o` both hold the new result, and every other `cc_o` bit is unchanged.
- R9: In a cycle without a strobe, `cc_o` and `result_o` hold their values and `invalid_o` is 0, whatever the other inputs are.
- R10: After synchronous reset, `cc_o`, `result_o` and `invalid_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strobe_i | input | 1 | Perform a compare this cycle |
| op_a_i | input | 64 | Operand A |
| op_b_i | input | 64 | Operand B |
| dbl_i | input | 1 | 1 = double precision, 0 = single precision |
| abs_i | input | 1 | Compare absolute values |
| cond_i | input | 4 | Condition mask: [3] signalling, [2] less, [1] equal, [0] unordered |
| cc_sel_i | input | 3 | Index of the condition-code bit to write |
| result_o | output | 1 | Result of the last compare |
| cc_o | output | 8 | Condition-code vector |
| invalid_o | output | 1 | Invalid-operation pulse |

## Verification
The bench sweeps every pair drawn from the following operand set, in both formats, with every condition mask and both abs settings:

- signed zeros
- subnormals
- normals that differ only in fraction
- infinities
- quiet, negative-quiet and signaling NaNs

Several kinds of faulty design would show up as a wrong result in this sweep:

- one that compares raw bit patterns: it makes -0 less than +0 and orders negative values backwards
- one that forgets the abs flag or lets it act on NaNs
- one that takes single operands from the wrong half of the input word

A design that misclassifies the quiet bit fails the check on the invalid pulse. The bench also checks that a NaN compare under the signalling mask bit leaves no trace on `invalid_o` in a non-strobe cycle. Finally, it watches all eight condition-code bits after each write to catch a write that lands on the wrong index or disturbs its neighbours.

// File: rtl/fpcmp_pkg.sv
// Package: shared widths and the unpacked operand view for the compare unit.
// Assumes IEEE-754 binary32 and binary64 encodings.
package fpcmp_pkg;
    localparam int OP_W      = 64;
    localparam int MAG_W     = OP_W - 1;
    localparam int SP_W      = 32;
    localparam int SP_EXP_W  = 8;
    localparam int SP_FRAC_W = 23;
    localparam int DP_EXP_W  = 11;
    localparam int DP_FRAC_W = 52;

    // Sign, magnitude field (exponent and fraction) and NaN class of one operand
    typedef struct packed {
        logic             sign;
        logic [MAG_W-1:0] mag;
        logic             is_nan;
        logic             is_snan;
    } fp_view_t;
endpackage

// File: rtl/fpcmp_unpack.sv
// Module: fpcmp_unpack
// Splits one operand into sign, zero-extended magnitude and NaN class for the
// selected format. Assumes that a single-precision operand sits in the low 32 bits.
module fpcmp_unpack
    import fpcmp_pkg::*;
(
    input  logic [OP_W-1:0] op_i,
    input  logic            dbl_i,
    output fp_view_t        view_o
);
    localparam int SP_MAG_W = SP_W - 1;
    localparam int DP_MAG_W = OP_W - 1;

    fp_view_t sp_view;
    fp_view_t dp_view;

    // Single-precision decode of the low word
    always_comb begin
        sp_view.sign    = op_i[SP_W-1];
        sp_view.mag     = {{(MAG_W-SP_MAG_W){1'b0}}, op_i[SP_MAG_W-1:0]};
        sp_view.is_nan  = (&op_i[SP_MAG_W-1:SP_FRAC_W]) && (|op_i[SP_FRAC_W-1:0]);
        sp_view.is_snan = sp_view.is_nan && !op_i[SP_FRAC_W-1];
    end

    // Double-precision decode of the full word
    always_comb begin
        dp_view.sign    = op_i[OP_W-1];
        dp_view.mag     = op_i[DP_MAG_W-1:0];
        dp_view.is_nan  = (&op_i[DP_MAG_W-1:DP_FRAC_W]) && (|op_i[DP_FRAC_W-1:0]);
        dp_view.is_snan = dp_view.is_nan && !op_i[DP_FRAC_W-1];
    end

    // Format select
    always_comb view_o = dbl_i ? dp_view : sp_view;
endmodule

// File: rtl/fpcmp_order.sv
// Module: fpcmp_order
// Sign-magnitude ordering of two non-NaN operands. Both zeros compare equal.
// Assumes that the caller masks the outputs when either operand is a NaN.
module fpcmp_order
    import fpcmp_pkg::*;
(
    input  logic             sign_a_i,
    input  logic [MAG_W-1:0] mag_a_i,
    input  logic             sign_b_i,
    input  logic [MAG_W-1:0] mag_b_i,
    input  logic             abs_i,
    output logic             lt_o,
    output logic             eq_o
);
    logic sa, sb, both_zero, mag_lt, mag_gt, mag_eq;

    // Effective signs after the optional absolute-value step
    always_comb begin
        sa = sign_a_i & ~abs_i;
        sb = sign_b_i & ~abs_i;
    end

    // Raw magnitude relations
    always_comb begin
        mag_lt    = mag_a_i < mag_b_i;
        mag_gt    = mag_a_i > mag_b_i;
        mag_eq    = mag_a_i == mag_b_i;
        both_zero = (mag_a_i == '0) && (mag_b_i == '0);
    end

    // Equal and strictly-less from the signs and the magnitudes
    always_comb begin
        eq_o = both_zero || (mag_eq && (sa == sb));
        if (eq_o)          lt_o = 1'b0;
        else if (sa != sb) lt_o = sa;
        else if (sa)       lt_o = mag_gt;
        else               lt_o = mag_lt;
    end
endmodule

// File: rtl/fpcmp_cond_unit.sv
// Module: fpcmp_cond_unit
// Compares two IEEE operands under a condition mask and latches the result
// into a selected condition-code bit. It also raises an invalid pulse on an
// unordered compare that signals. All outputs are registered.
// Assumes a synchronous active-low reset.
module fpcmp_cond_unit
    import fpcmp_pkg::*;
#(
    parameter int NUM_CC = 8,
    localparam int SEL_W = $clog2(NUM_CC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe_i,
    input  logic [63:0]       op_a_i,
    input  logic [63:0]       op_b_i,
    input  logic              dbl_i,
    input  logic              abs_i,
    input  logic [3:0]        cond_i,
    input  logic [SEL_W-1:0]  cc_sel_i,
    output logic              result_o,
    output logic [NUM_CC-1:0] cc_o,
    output logic              invalid_o
);
    localparam logic [NUM_CC-1:0] CC_ONE = NUM_CC'(1);

    fp_view_t va, vb;
    logic     lt, eq, unord, less_t, equal_t, res_c, inv_c;

    fpcmp_unpack u_unpack_a (.op_i(op_a_i), .dbl_i(dbl_i), .view_o(va));
    fpcmp_unpack u_unpack_b (.op_i(op_b_i), .dbl_i(dbl_i), .view_o(vb));

    fpcmp_order u_order (
        .sign_a_i (va.sign),
        .mag_a_i  (va.mag),
        .sign_b_i (vb.sign),
        .mag_b_i  (vb.mag),
        .abs_i    (abs_i),
        .lt_o     (lt),
        .eq_o     (eq)
    );

    // Relation terms: a NaN forces unordered and suppresses less and equal
    always_comb begin
        unord   = va.is_nan | vb.is_nan;
        less_t  = lt & ~unord;
        equal_t = eq & ~unord;
    end

    // Masked condition result and invalid-operation detect
    always_comb begin
        res_c = (cond_i[2] & less_t) | (cond_i[1] & equal_t) | (cond_i[0] & unord);
        inv_c = unord & (cond_i[3] | va.is_snan | vb.is_snan);
    end

    // Output registers: condition-code write, result latch, invalid pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cc_o      <= '0;
            result_o  <= 1'b0;
            invalid_o <= 1'b0;
        end else begin
            invalid_o <= strobe_i & inv_c;
            if (strobe_i) begin
                cc_o[cc_sel_i] <= res_c;
                result_o       <= res_c;
            end
        end
    end

    // R6: less and equal are never both asserted by the ordering stage
    a_r6_lt_eq_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(lt && eq));

    // R3: an unordered compare produces neither less nor equal
    a_r3_nan_unordered: assert property (@(posedge clk) disable iff (!rst_n)
        unord |-> !(less_t || equal_t));

    // R8: the selected bit receives the result and the other bits keep their values
    a_r8_cc_write: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_i |=> (cc_o[$past(cc_sel_i)] == result_o) &&
                     (((cc_o ^ $past(cc_o)) & ~(CC_ONE << $past(cc_sel_i))) == '0));

    // R9: without a strobe the state holds and no invalid pulse appears
    a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe_i |=> $stable(cc_o) && $stable(result_o) && !invalid_o);

    // R4: an invalid pulse follows only a strobed compare
    a_r4_invalid_src: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(invalid_o) |-> $past(strobe_i));
endmodule

// File: tb/tb_fpcmp_cond_unit.sv
// Bench: sweeps every operand pair from a class table in both formats, with
// all condition masks and both abs settings. The expected order comes from
// integer ranks held in the bench.
module tb_fpcmp_cond_unit;
    localparam int NV = 15;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strobe = 1'b0;
    logic [63:0] op_a = '0, op_b = '0;
    logic        dbl = 1'b0, abs_f = 1'b0;
    logic [3:0]  cond = '0;
    logic [2:0]  sel = '0;
    logic        result, invalid;
    logic [7:0]  cc;

    int          checks = 0, fails = 0;
    logic [7:0]  exp_cc = '0;
    logic        exp_res = 1'b0;

    fpcmp_cond_unit dut (
        .clk(clk), .rst_n(rst_n), .strobe_i(strobe), .op_a_i(op_a), .op_b_i(op_b),
        .dbl_i(dbl), .abs_i(abs_f), .cond_i(cond), .cc_sel_i(sel),
        .result_o(result), .cc_o(cc), .invalid_o(invalid)
    );

    always #10 clk = ~clk;   // 50 MHz

    // Class table: 0..11 ordered values, 12 qNaN, 13 sNaN, 14 negative qNaN
    function automatic int rank_of(int i);
        case (i)
            0: return -100; 1: return -20; 2: return -15; 3: return -10;
            4: return -1;   5: return 0;   6: return 0;   7: return 1;
            8: return 10;   9: return 15;  10: return 20; default: return 100;
        endcase
    endfunction

    function automatic logic [63:0] bits_of(int i, logic d);
        logic [31:0] s;
        logic [63:0] w;
        case (i)
            0:  begin s = 32'hFF800000; w = 64'hFFF0000000000000; end
            1:  begin s = 32'hC0000000; w = 64'hC000000000000000; end
            2:  begin s = 32'hBFC00000; w = 64'hBFF8000000000000; end
            3:  begin s = 32'hBF800000; w = 64'hBFF0000000000000; end
            4:  begin s = 32'h80000001; w = 64'h8000000000000001; end
            5:  begin s = 32'h80000000; w = 64'h8000000000000000; end
            6:  begin s = 32'h00000000; w = 64'h0000000000000000; end
            7:  begin s = 32'h00000001; w = 64'h0000000000000001; end
            8:  begin s = 32'h3F800000; w = 64'h3FF0000000000000; end
            9:  begin s = 32'h3FC00000; w = 64'h3FF8000000000000; end
            10: begin s = 32'h40000000; w = 64'h4000000000000000; end
            11: begin s = 32'h7F800000; w = 64'h7FF0000000000000; end
            12: begin s = 32'h7FC00000; w = 64'h7FF8000000000000; end
            13: begin s = 32'h7F800001; w = 64'h7FF0000000000001; end
            default: begin s = 32'hFFC00000; w = 64'hFFF8000000000000; end
        endcase
        // R1: the upper word carries junk in single format
        return d ? w : {32'hDEADBEEF, s};
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic run_cmp(input logic d, input int i, input int j, input int c,
                           input logic ab, input logic [2:0] s);
        bit nan_a, nan_b, sn_a, sn_b, unord, less, eq, inv;
        int ra, rb;
        string tag;
        @(negedge clk);
        op_a = bits_of(i, d); op_b = bits_of(j, d);
        dbl = d; abs_f = ab; cond = 4'(c); sel = s; strobe = 1'b1;
        @(negedge clk);
        strobe = 1'b0;
        nan_a = (i >= 12); nan_b = (j >= 12);
        sn_a = (i == 13);  sn_b = (j == 13);
        unord = nan_a || nan_b;                      // R3
        ra = rank_of(i); rb = rank_of(j);
        if (ab) begin                                // R5
            if (ra < 0) ra = -ra;
            if (rb < 0) rb = -rb;
        end
        less = !unord && (ra < rb);                  // R6
        eq   = !unord && (ra == rb);
        // R7: masked OR of the three relations
        exp_res = (cond[2] & less) | (cond[1] & eq) | (cond[0] & unord);
        inv = unord && (cond[3] || sn_a || sn_b);
        exp_cc[s] = exp_res;
        if (unord)                           tag = "R3";
        else if (ra == rb && i != j)         tag = "R6";
        else if (ab)                         tag = "R5";
        else if (d)                          tag = "R2";
        else                                 tag = "R1";
        chk({tag, " result"}, 64'(result), 64'(exp_res));
        chk("R4 invalid", 64'(invalid), 64'(inv));
        chk("R8 cc vector", 64'(cc), 64'(exp_cc));
    endtask

    // Watchdog: counts as a failure and still prints the summary
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        chk("R10 cc", 64'(cc), 64'h0);
        chk("R10 result", 64'(result), 64'h0);
        chk("R10 invalid", 64'(invalid), 64'h0);
        for (int f = 0; f < 2; f++) begin
            for (int i = 0; i < NV; i++) begin
                for (int j = 0; j < NV; j++)
                    for (int c = 0; c < 16; c++)
                        for (int ab = 0; ab < 2; ab++) begin
                            run_cmp(f[0], i, j, c, ab[0], n[2:0]);
                            n = n + 3;
                        end
                // R9: a would-be invalid NaN compare without a strobe changes nothing
                op_a = bits_of(13, f[0]); op_b = bits_of(i, f[0]);
                cond = 4'hF; sel = 3'(i);
                @(negedge clk);
                chk("R9 cc hold", 64'(cc), 64'(exp_cc));
                chk("R9 result hold", 64'(result), 64'(exp_res));
                chk("R9 invalid low", 64'(invalid), 64'h0);
            end
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule